// File: doc/BRIEF.md
# Timestamped Checkpoint Trace Capture

The block listens to an 8-bit parallel bus driven by a device under test. Each time the device raises its write strobe, the block takes the 8-bit checkpoint code from the bus and pairs it with a free-running timestamp in microseconds. The pair is stored as one 40-bit record in an internal buffer. Records are kept in arrival order, so a host that drains them sees a time-ordered profile of the device's execution.

The strobe and data come from another clock domain. The strobe passes through a two-flop synchronizer, and the data bus is sampled one cycle after the synchronized rising edge. A parameterized divider of the system clock produces the 1 µs tick that drives a 32-bit wrapping timestamp counter. The host drains records through a valid/ready port. If a strobe arrives while the buffer is full, that record is dropped and a sticky overflow flag is raised. The block also drives a power-enable output to the device. This output is low in reset and high once the block is running.

Top module: `ckpt_trace_top`

## Requirements
- R1: While rst_ni is low, rec_valid_o, ovf_o and pwr_en_o are all 0.
- R2: pwr_en_o goes to 1 on the first clock edge after reset is released and then stays at 1.
- R3: Each low-to-high transition of cp_strobe_i creates exactly one record, however long the strobe stays high. When the buffer is empty, rec_valid_o is 1 after the fourth rising clock edge that sees the strobe high, and not before.
- R4: A record holds the checkpoint code in bits 7:0 and the timestamp in bits 39:8.
- R5: The timestamp counts CLK_PER_US clock cycles per step from 0 at reset and wraps modulo 2^32. Let N be the number of clock edges since reset up to and including the second edge that sees the strobe high. A record carries floor(N / CLK_PER_US).
- R6: Records leave in the same order in which their strobes arrived.
- R7: A record leaves when rec_valid_o and rec_ready_i are both 1 at a clock edge. While rec_valid_o is 1 and rec_ready_i is 0, rec_data_o holds its value.
- R8: A strobe that arrives while FIFO_DEPTH records are stored is dropped. The stored records are left unchanged, and ovf_o becomes 1 and stays 1.
- R9: A one-cycle pulse on ovf_clr_i clears ovf_o. If a drop happens in the same cycle, the drop wins and ovf_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_data_i | input | 8 | Checkpoint code bus from the device |
| cp_strobe_i | input | 1 | Write strobe from the device, asynchronous |
| ovf_clr_i | input | 1 | Pulse that clears the overflow flag |
| rec_ready_i | input | 1 | Host accepts the current record |
| rec_valid_o | output | 1 | A record is available |
| rec_data_o | output | 40 | Record: timestamp in 39:8, code in 7:0 |
| ovf_o | output | 1 | Sticky flag: a record was dropped |
| pwr_en_o | output | 1 | Power enable to the device |

## Verification
The bound checker watches these rules on every cycle:
- the reset values;
- the power enable staying on once set;
- the timestamp moving by one step at most;
- held records staying stable under back-pressure;
- a drop raising the overflow flag, and the flag holding until it is cleared.

Other rules need a chain of stimulus, so only the bench scenarios can show them:
- the exact latency from strobe to record;
- the timestamp value in each record;
- one record per held strobe;
- arrival order;
- which record is lost on overflow.

// File: rtl/ckpt_trace_pkg.sv
package ckpt_trace_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned TS_W   = 32;
  localparam int unsigned REC_W  = TS_W + CODE_W;

  typedef struct packed {
    logic [TS_W-1:0]   ts;
    logic [CODE_W-1:0] code;
  } ckpt_rec_t;
endpackage

// File: rtl/ckpt_us_timer.sv
module ckpt_us_timer #(
  parameter int unsigned CLK_PER_US = 50
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic [ckpt_trace_pkg::TS_W-1:0] ts_o
);
  localparam int unsigned DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] DIV_MAX = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick = (div_q == DIV_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ts_o  <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) ts_o <= ts_o + 1'b1;  // wraps modulo 2^TS_W
    end
  end
endmodule

// File: rtl/ckpt_strobe_capture.sv
module ckpt_strobe_capture
  import ckpt_trace_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic [TS_W-1:0]   ts_i,
  output logic              push_o,
  output ckpt_rec_t         rec_o
);
  logic [2:0]      sync_q;
  logic            rise;
  logic            pend_q;
  logic [TS_W-1:0] ts_lat_q;

  // sync_q[1:0] synchronize, sync_q[2] holds last state for edge detect
  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      pend_q   <= 1'b0;
      ts_lat_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], strobe_i};
      pend_q <= rise;
      if (rise) ts_lat_q <= ts_i;
    end
  end

  // data bus sampled one cycle after the synchronized edge
  assign push_o    = pend_q;
  assign rec_o.ts   = ts_lat_q;
  assign rec_o.code = data_i;
endmodule

// File: rtl/ckpt_rec_fifo.sv
module ckpt_rec_fifo
  import ckpt_trace_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      push_i,
  input  ckpt_rec_t wdata_i,
  input  logic      pop_i,
  output ckpt_rec_t rdata_o,
  output logic      empty_o,
  output logic      full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  ckpt_rec_t     mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign do_wr   = push_i & ~full_o;
  assign do_rd   = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/ckpt_trace_top.sv
module ckpt_trace_top
  import ckpt_trace_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 50,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CODE_W-1:0] cp_data_i,
  input  logic             cp_strobe_i,
  input  logic             ovf_clr_i,
  input  logic             rec_ready_i,
  output logic             rec_valid_o,
  output logic [REC_W-1:0] rec_data_o,
  output logic             ovf_o,
  output logic             pwr_en_o
);
  logic [TS_W-1:0] ts_now;
  logic            cap_push;
  ckpt_rec_t       cap_rec, head_rec;
  logic            fifo_empty, fifo_full;

  ckpt_us_timer #(.CLK_PER_US(CLK_PER_US)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ts_o   (ts_now)
  );

  ckpt_strobe_capture i_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (cp_strobe_i),
    .data_i   (cp_data_i),
    .ts_i     (ts_now),
    .push_o   (cap_push),
    .rec_o    (cap_rec)
  );

  ckpt_rec_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (cap_push),
    .wdata_i (cap_rec),
    .pop_i   (rec_ready_i),
    .rdata_o (head_rec),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign rec_valid_o = ~fifo_empty;
  assign rec_data_o  = head_rec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o    <= 1'b0;
      pwr_en_o <= 1'b0;
    end else begin
      pwr_en_o <= 1'b1;
      if (cap_push && fifo_full) ovf_o <= 1'b1;  // drop wins over clear
      else if (ovf_clr_i)        ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ckpt_trace_chk.sv
module ckpt_trace_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pwr_en_o,
  input logic        rec_valid_o,
  input logic        rec_ready_i,
  input logic [39:0] rec_data_o,
  input logic        ovf_o,
  input logic        ovf_clr_i,
  input logic [31:0] ts_q,
  input logic        push,
  input logic        full
);
  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (!rec_valid_o && !ovf_o && !pwr_en_o));

  // R2
  pwr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_en_o |=> pwr_en_o);

  // R5
  ts_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_q != $past(ts_q)) |-> (ts_q == $past(ts_q) + 32'd1));

  // R7
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && !rec_ready_i) |=> (rec_valid_o && $stable(rec_data_o)));

  // R8
  drop_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full) |=> ovf_o);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
endmodule

bind ckpt_trace_top ckpt_trace_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwr_en_o    (pwr_en_o),
  .rec_valid_o (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_data_o  (rec_data_o),
  .ovf_o       (ovf_o),
  .ovf_clr_i   (ovf_clr_i),
  .ts_q        (ts_now),
  .push        (cap_push),
  .full        (fifo_full)
);

// File: tb/test_ckpt_trace_top.sv
module test_ckpt_trace_top;
  localparam int unsigned DIV   = 5;
  localparam int unsigned DEPTH = 4;
  localparam int unsigned NVEC  = 6;
  localparam logic [7:0] VEC_CODE [NVEC] = '{8'h00, 8'hFF, 8'h5A, 8'hA5, 8'h01, 8'h80};
  localparam int unsigned VEC_IDLE [NVEC] = '{3, 7, 11, 2, 19, 5};

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0]  cp_data_i = '0;
  logic        cp_strobe_i = 1'b0, ovf_clr_i = 1'b0, rec_ready_i = 1'b0;
  logic        rec_valid_o, ovf_o, pwr_en_o;
  logic [39:0] rec_data_o;
  int          checks = 0, failures = 0;
  int unsigned n_edges = 0;
  logic [31:0] exp_ts [8];

  ckpt_trace_top #(.CLK_PER_US(DIV), .FIFO_DEPTH(DEPTH)) i_ckpt_trace_top (
    .clk_i, .rst_ni, .cp_data_i, .cp_strobe_i, .ovf_clr_i, .rec_ready_i,
    .rec_valid_o, .rec_data_o, .ovf_o, .pwr_en_o
  );

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) if (rst_ni) n_edges <= n_edges + 1;

  task automatic chk(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // drive one strobe; return the expected timestamp, optionally check latency (R3)
  task automatic send(input logic [7:0] code, input int hold, input bit lat_chk, output logic [31:0] ts);
    int unsigned e;
    cp_data_i   = code;
    cp_strobe_i = 1'b1;
    e  = n_edges;
    ts = 32'((e + 2) / DIV);
    wcyc(3);
    if (lat_chk) chk(!rec_valid_o, "R3 early", {39'd0, rec_valid_o}, 40'd0);
    wcyc(1);
    if (lat_chk) chk(rec_valid_o, "R3 latency", {39'd0, rec_valid_o}, 40'd1);
    wcyc(hold - 4);
    cp_strobe_i = 1'b0;
    wcyc(3);
  endtask

  task automatic take(input logic [7:0] code, input logic [31:0] ts, input string req);
    chk(rec_valid_o, req, {39'd0, rec_valid_o}, 40'd1);
    chk(rec_data_o == {ts, code}, req, rec_data_o, {ts, code});
    rec_ready_i = 1'b1;
    wcyc(1);
    rec_ready_i = 1'b0;
  endtask

  initial begin
    logic [31:0] t;
    wcyc(2);
    // R1
    chk(!rec_valid_o && !ovf_o && !pwr_en_o, "R1 reset",
        {37'd0, rec_valid_o, ovf_o, pwr_en_o}, 40'd0);
    rst_ni = 1'b1;
    wcyc(1);
    chk(pwr_en_o, "R2 power", {39'd0, pwr_en_o}, 40'd1);

    // vector walk: R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      wcyc(VEC_IDLE[i]);
      send(VEC_CODE[i], 4, 1'b1, t);
      take(VEC_CODE[i], t, "R4 R5 record");
      chk(!rec_valid_o, "R3 single", {39'd0, rec_valid_o}, 40'd0);
    end

    // long strobe gives one record (R3)
    send(8'h3C, 25, 1'b1, t);
    take(8'h3C, t, "R3 long");
    chk(!rec_valid_o, "R3 one per edge", {39'd0, rec_valid_o}, 40'd0);

    // order and back-pressure (R6, R7)
    for (int i = 0; i < 3; i++) send(8'h10 + 8'(i), 4, 1'b0, exp_ts[i]);
    wcyc(4);
    chk(rec_data_o == {exp_ts[0], 8'h10}, "R7 stall", rec_data_o, {exp_ts[0], 8'h10});
    for (int i = 0; i < 3; i++) take(8'h10 + 8'(i), exp_ts[i], "R6 order");
    chk(!rec_valid_o, "R6 drained", {39'd0, rec_valid_o}, 40'd0);

    // overflow (R8, R9)
    chk(!ovf_o, "R8 no ovf yet", {39'd0, ovf_o}, 40'd0);
    for (int i = 0; i < DEPTH; i++) send(8'h20 + 8'(i), 4, 1'b0, exp_ts[i]);
    chk(!ovf_o, "R8 full no drop", {39'd0, ovf_o}, 40'd0);
    send(8'hEE, 4, 1'b0, t);
    chk(ovf_o, "R8 drop flag", {39'd0, ovf_o}, 40'd1);
    wcyc(5);
    chk(ovf_o, "R8 sticky", {39'd0, ovf_o}, 40'd1);
    for (int i = 0; i < DEPTH; i++) take(8'h20 + 8'(i), exp_ts[i], "R8 kept");
    chk(!rec_valid_o, "R8 dropped gone", {39'd0, rec_valid_o}, 40'd0);
    chk(ovf_o, "R8 sticky after drain", {39'd0, ovf_o}, 40'd1);
    ovf_clr_i = 1'b1;
    wcyc(1);
    ovf_clr_i = 1'b0;
    chk(!ovf_o, "R9 clear", {39'd0, ovf_o}, 40'd0);
    chk(pwr_en_o, "R2 still on", {39'd0, pwr_en_o}, 40'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule